// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Bank

This block watches eight external input pins and raises per-channel interrupt status when the trigger condition chosen for that channel occurs. Each pin first passes through a two-flop synchronizer. The synchronized value is readable as the input data word. A third flop keeps the previous sample, and edges are found by comparing the current sample with that previous one.

Three configuration bits per channel choose the trigger:
- a mode bit selects level (1) or edge (0);
- a polarity bit selects high/rising (1) or low/falling (0);
- a both-edge bit makes any transition trigger in edge mode, whatever the polarity.

A trigger sets a sticky raw status bit. Software acknowledges a channel by writing a 1 to the clear register. The enable register gates raw status into masked status, and one interrupt output is the OR of all masked bits.

Software reaches the registers through a simple word bus with a write strobe, a byte address and a combinational read port. Addresses are compared in full. Every offset that is not mapped reads as zero.

Top module: `edge_level_irq_bank`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low. The mapped offsets are: enable 0x00, raw status 0x04, masked status 0x08, clear 0x0C, mode 0x10, both-edge 0x14, polarity 0x18, input data 0x1C.
- R2: In edge mode (mode bit 0, both-edge bit 0) with polarity 1, a 0-to-1 transition of the synchronized input sets the channel's raw status bit. The bit stays set until it is cleared.
- R3: In edge mode (mode bit 0, both-edge bit 0) with polarity 0, a 1-to-0 transition sets the raw status bit. A transition of the other direction does not set it.
- R4: In edge mode with the both-edge bit at 1, either transition sets the raw status bit, whatever the polarity bit holds.
- R5: In level mode (mode bit 1) the raw status bit is set in every cycle in which the synchronized input equals the polarity bit, including the cycle right after a clear. The both-edge bit has no effect in this mode.
- R6: Writing the clear offset clears exactly the raw status bits written as 1. Bits written as 0 keep their value.
- R7: If a clear and a new trigger reach the same channel in the same cycle, the trigger wins and the raw status bit stays set.
- R8: Masked status equals raw status AND enable. `irq_out` is high exactly when some masked status bit is 1.
- R9: The input data offset returns each pin's value two clocks after it is sampled.
- R10: The clear offset and all unmapped offsets read zero. Writes to raw status, masked status and input data are ignored.
- R11: The enable, mode, both-edge and polarity registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_in | input | NCH | External input pins, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | NCH | Register write data |
| bus_rdata | output | NCH | Register read data, combinational from bus_addr |
| irq_out | output | 1 | OR of all masked status bits |

## Verification
The bench drives mixed per-channel configurations in one vector: edge, both-edge and level channels are active at the same time. This exposes a selection mux that applies one channel's setting to another. It also exposes a both-edge bit that wrongly still honours polarity.

A clear is placed in the exact cycle a new edge reaches the edge detector. A design that gives the clear priority would drop that interrupt. A clear is also issued while a level condition persists, and a design that does not re-set the bit at once would read zero.

Partial clears, writes to read-only offsets and reads of unmapped offsets are checked at the read port. An incorrect decoder would show up there as disturbed status or non-zero data.

// File: rtl/edge_level_irq_bank.sv
module edge_level_irq_bank #(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pins_in,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [NCH-1:0] bus_wdata,
  output logic [NCH-1:0] bus_rdata,
  output logic           irq_out
);
  localparam logic [AW-1:0] A_EN   = AW'('h00);
  localparam logic [AW-1:0] A_RAW  = AW'('h04);
  localparam logic [AW-1:0] A_MSK  = AW'('h08);
  localparam logic [AW-1:0] A_CLR  = AW'('h0C);
  localparam logic [AW-1:0] A_MODE = AW'('h10);
  localparam logic [AW-1:0] A_BOTH = AW'('h14);
  localparam logic [AW-1:0] A_POL  = AW'('h18);
  localparam logic [AW-1:0] A_DATA = AW'('h1C);

  logic [NCH-1:0] s1_q, s2_q, s3_q;
  logic [NCH-1:0] en_q, mode_q, both_q, pol_q, raw_q;
  logic [NCH-1:0] rise, fall, edge_hit, lvl_hit, evt, clr_mask, masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pins_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise     = s2_q & ~s3_q;
  assign fall     = ~s2_q & s3_q;
  assign edge_hit = (both_q & (rise | fall)) |
                    (~both_q & ((pol_q & rise) | (~pol_q & fall)));
  assign lvl_hit  = (pol_q & s2_q) | (~pol_q & ~s2_q);
  assign evt      = (mode_q & lvl_hit) | (~mode_q & edge_hit);
  assign clr_mask = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;
  assign masked   = raw_q & en_q;
  assign irq_out  = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      raw_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | evt;
      if (bus_we) begin
        case (bus_addr)
          A_EN:    en_q   <= bus_wdata;
          A_MODE:  mode_q <= bus_wdata;
          A_BOTH:  both_q <= bus_wdata;
          A_POL:   pol_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = en_q;
      A_RAW:   bus_rdata = raw_q;
      A_MSK:   bus_rdata = masked;
      A_MODE:  bus_rdata = mode_q;
      A_BOTH:  bus_rdata = both_q;
      A_POL:   bus_rdata = pol_q;
      A_DATA:  bus_rdata = s2_q;
      default: bus_rdata = '0;
    endcase
  end

  // Raw bits only fall when a clear was written for them.
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((raw_q & $past(raw_q & ~clr_mask)) == $past(raw_q & ~clr_mask)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((raw_q & $past(clr_mask & ~evt)) == '0));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((raw_q & $past(evt & clr_mask)) == $past(evt & clr_mask)));

  p_level_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((raw_q & $past(mode_q & pol_q & s2_q)) == $past(mode_q & pol_q & s2_q)));
endmodule

// File: tb/edge_level_irq_bank_test.sv
module edge_level_irq_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_in = '0;
  logic       bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_out;
  int         n_total = 0;
  int         n_fail = 0;
  logic [7:0] rv, ev;

  always #2 clk = ~clk;

  edge_level_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out));

  // {mode, both, pol, pins_a, pins_b}
  localparam logic [39:0] VEC [6] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'hF0},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h0F},
    {8'h00, 8'hFF, 8'h0F, 8'h55, 8'h3C},
    {8'hFF, 8'h00, 8'hAA, 8'h00, 8'h0F},
    {8'h0F, 8'hF0, 8'h33, 8'hC3, 8'h96},
    {8'h00, 8'h00, 8'h5A, 8'h00, 8'hFF}
  };

  function automatic logic [7:0] model(input logic [7:0] m, bo, p, a, b);
    logic [7:0] la, lb, r, f, e;
    la = (p & a) | (~p & ~a);
    lb = (p & b) | (~p & ~b);
    r  = b & ~a;
    f  = a & ~b;
    e  = (bo & (r | f)) | (~bo & ((p & r) | (~p & f)));
    return (m & (la | lb)) | (~m & e);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_total++; n_fail++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(6'(i * 4), rv);
      check("R1 reset reg", rv, 8'h00);
    end
    check("R1 reset irq", {7'b0, irq_out}, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R11 readback
    wr(6'h10, 8'hA5); rd(6'h10, rv); check("R11 mode", rv, 8'hA5);
    wr(6'h14, 8'h3C); rd(6'h14, rv); check("R11 both", rv, 8'h3C);
    wr(6'h18, 8'h81); rd(6'h18, rv); check("R11 pol", rv, 8'h81);

    wr(6'h00, 8'h3C);
    // Table walk: R2 R3 R4 R5 R8 R9
    for (int k = 0; k < 6; k++) begin
      logic [7:0] m, bo, p, a, b;
      {m, bo, p, a, b} = VEC[k];
      wr(6'h10, m); wr(6'h14, bo); wr(6'h18, p);
      pins_in = a;
      idle(4);
      wr(6'h0C, 8'hFF);
      pins_in = b;
      idle(5);
      ev = model(m, bo, p, a, b);
      rd(6'h04, rv); check("R2/R3/R4/R5 raw", rv, ev);
      rd(6'h08, rv); check("R8 masked", rv, ev & 8'h3C);
      check("R8 irq", {7'b0, irq_out}, {7'b0, |(ev & 8'h3C)});
      rd(6'h1C, rv); check("R9 data", rv, b);
    end

    // R6 partial clear: all edge rising, toggle all pins up
    wr(6'h10, 8'h00); wr(6'h14, 8'h00); wr(6'h18, 8'hFF);
    pins_in = 8'h00; idle(4); wr(6'h0C, 8'hFF);
    pins_in = 8'hFF; idle(5);
    rd(6'h04, rv); check("R2 sticky", rv, 8'hFF);
    wr(6'h0C, 8'h0F);
    rd(6'h04, rv); check("R6 partial clear", rv, 8'hF0);

    // R10 writes to status/data ignored, reads of clear/unmapped zero
    wr(6'h04, 8'h00); wr(6'h08, 8'h00); wr(6'h1C, 8'h00);
    rd(6'h04, rv); check("R10 raw unchanged", rv, 8'hF0);
    rd(6'h1C, rv); check("R10 data unchanged", rv, 8'hFF);
    rd(6'h0C, rv); check("R10 clear reads zero", rv, 8'h00);
    rd(6'h20, rv); check("R10 unmapped zero", rv, 8'h00);
    rd(6'h05, rv); check("R10 unaligned zero", rv, 8'h00);

    // R7 clear and rising edge same cycle
    pins_in = 8'h00; idle(4); wr(6'h0C, 8'hFF);
    @(negedge clk); pins_in = 8'h01;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'h0C; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_we = 1'b0;
    rd(6'h04, rv); check("R7 event wins", rv, 8'h01);

    // R5 level reasserts right after clear; both-edge ignored
    wr(6'h10, 8'h01); wr(6'h14, 8'h01); wr(6'h18, 8'h00);
    pins_in = 8'h00; idle(4);
    wr(6'h0C, 8'hFF);
    rd(6'h04, rv); check("R5 level reassert", rv, 8'h01);
    pins_in = 8'h01; idle(4); wr(6'h0C, 8'hFF);
    rd(6'h04, rv); check("R5 level gone cleared", rv, 8'h00);
    wr(6'h00, 8'h00);
    check("R8 irq low", {7'b0, irq_out}, 8'h00);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule